// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Periodic Tick and Trim

This block turns the free-running low-frequency source clock of a real-time clock into a one-second tick for the calendar counters. It divides by a power of two set at build time: 2^15 cycles for a 32.768 kHz crystal. It also raises a periodic event at a rate chosen by a 4-bit code, anywhere from 1/64 s to 1 s. The event sets a sticky flag, and the flag can drive an interrupt line.

For crystal error, the block can shorten or lengthen one second in every 10-second or 60-second interval by up to 63 source cycles. Shortening makes the clock gain time. Lengthening makes it lose time. Software sets the rate, the enable bits, the interval choice and the trim value through four byte-wide registers. Writes are held off for a few cycles after reset.

Top module: `rtc_prescaler_trim`

## Requirements
- R1: After reset all four registers read 0x00, and `sec_tick`, `tick_period` and `irq_period` are low.
- R2: Register writes are ignored until GUARD_CYC (6) clock cycles after reset is released. Writes made after that are accepted.
- R3: While the run bit (address 1, bit 0) is 1 and no trim is due, `sec_tick` pulses once every 2^SEC_W cycles. While run is 0, neither `sec_tick` nor `tick_period` pulses.
- R4: The rate code at address 0, bits 7:4, selects the spacing of `tick_period` pulses. A code c from 8 to 14 gives a period of 2^(c-14) s, which is 2^(SEC_W-14+c) cycles, so code 8 gives 1/64 s. Any other code gives no pulses.
- R5: Each `tick_period` pulse sets the periodic flag (address 2, bit 2). Writing 0 to that bit clears the flag. Writing 1 leaves it unchanged. A set in the same cycle as a clear wins.
- R6: `irq_period` is high exactly when the periodic flag is 1 and the interrupt enable (address 0, bit 2) is 1.
- R7: The trim register (address 3) holds a count N in bits 5:0 and a sign in bits 7:6. With sign 1 (add), the second that starts at the first tick of an interval lasts 2^SEC_W − N cycles.
- R8: With sign 2 (subtract), that second lasts 2^SEC_W + N cycles.
- R9: Sign 0 or sign 3 leaves every second at its normal length. Auto-trim enable (address 1, bit 4) at 0 does the same.
- R10: The interval bit (address 1, bit 5) at 1 applies the trim every 10 seconds. At 0 it applies the trim every 60 seconds. Seconds in between keep their normal length.
- R11: A write to address 1 while the trim sign is nonzero leaves the interval bit unchanged. The other bits of that write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| sec_tick | output | 1 | One-cycle pulse at each one-second boundary |
| tick_period | output | 1 | One-cycle pulse at the selected periodic rate |
| irq_period | output | 1 | Periodic interrupt request |

## Verification
A register write lands on the clock edge that samples the strobe, and its effect can be read back in the next cycle. The bench therefore reads each value at least one negative edge after the write cycle.

Both pulse outputs decode the divider state and are high for the one cycle in which the counter holds its terminal value. The bench samples them at negative edges and stamps each pulse with a count of rising edges, so every check compares a distance between two pulses. A trimmed second starts at the edge that consumes the first tick of an interval. Its length is measured from that tick to the next one: 2^SEC_W ∓ N cycles.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   typedef enum logic [1:0] {
      SGN_NONE = 2'd0,
      SGN_ADD  = 2'd1,
      SGN_SUB  = 2'd2,
      SGN_RSV  = 2'd3
   } trim_sign_e;

   localparam logic [1:0] A_RATE  = 2'd0;
   localparam logic [1:0] A_MODE  = 2'd1;
   localparam logic [1:0] A_STAT  = 2'd2;
   localparam logic [1:0] A_TRIM  = 2'd3;

   localparam logic [7:0] RATE_MASK = 8'hF4;
   localparam logic [7:0] MODE_MASK = 8'h31;

   localparam int BIT_RUN   = 0;
   localparam int BIT_AUTO  = 4;
   localparam int BIT_TEN   = 5;
   localparam int BIT_PIE   = 2;
   localparam int BIT_FLAG  = 2;

   localparam int TRIM_W     = 6;
   localparam int RATE_FIRST = 8;
   localparam int RATE_COUNT = 7;

endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
   import rtc_trim_pkg::*;
#(
   parameter int GUARD_CYC = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [7:0]          wr_data,
   input  logic [1:0]          rd_addr,
   output logic [7:0]          rd_data,
   input  logic                per_evt,
   output logic [3:0]          rate,
   output logic                pie,
   output logic                run,
   output logic                auto_en,
   output logic                ten_sec,
   output logic                flag,
   output logic [7:0]          trim
);

   localparam int GW = $clog2(GUARD_CYC + 1);

   generate
      if (GUARD_CYC < 1) begin : g_bad_guard
         $error("GUARD_CYC must be at least 1");
      end
   endgenerate

   logic [GW-1:0] guard_q;
   logic          wr_ok;
   logic          ten_lock;
   logic [7:0]    rate_q, mode_q, trim_q;
   logic          flag_q;

   assign wr_ok    = (guard_q == GW'(GUARD_CYC));
   assign ten_lock = (trim_q[7:6] != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         guard_q <= '0;
      end else if (!wr_ok) begin
         guard_q <= guard_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
         mode_q <= '0;
         trim_q <= '0;
      end else if (wr_en && wr_ok) begin
         case (wr_addr)
            A_RATE: rate_q <= wr_data & RATE_MASK;
            A_MODE: begin
               mode_q <= wr_data & MODE_MASK;
               if (ten_lock) mode_q[BIT_TEN] <= mode_q[BIT_TEN];
            end
            A_TRIM: trim_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (per_evt) begin
         flag_q <= 1'b1;
      end else if (wr_en && wr_ok && wr_addr == A_STAT && !wr_data[BIT_FLAG]) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      case (rd_addr)
         A_RATE:  rd_data = rate_q;
         A_MODE:  rd_data = mode_q;
         A_STAT:  rd_data = {5'b0, flag_q, 2'b0};
         default: rd_data = trim_q;
      endcase
   end

   assign rate    = rate_q[7:4];
   assign pie     = rate_q[BIT_PIE];
   assign run     = mode_q[BIT_RUN];
   assign auto_en = mode_q[BIT_AUTO];
   assign ten_sec = mode_q[BIT_TEN];
   assign flag    = flag_q;
   assign trim    = trim_q;

   a_r2_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> ($stable(rate_q) && $stable(mode_q) && $stable(trim_q)));

   a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      per_evt |=> flag_q);

   a_r11_interval_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_MODE && ten_lock) |=> $stable(ten_sec));

endmodule

// File: rtl/rtc_trim_interval.sv
module rtc_trim_interval
   import rtc_trim_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              run,
   input  logic              auto_en,
   input  logic              ten_sec,
   input  logic [7:0]        trim,
   output logic              trim_add,
   output logic              trim_sub,
   output logic [TRIM_W-1:0] trim_n
);

   localparam logic [5:0] LAST_TEN   = 6'd9;
   localparam logic [5:0] LAST_SIXTY = 6'd59;

   logic [5:0] ic_q;
   logic [5:0] ic_last;
   logic       ten_q;
   logic       due;
   trim_sign_e sign;

   assign ic_last = ten_sec ? LAST_TEN : LAST_SIXTY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ic_q  <= '0;
         ten_q <= 1'b0;
      end else begin
         ten_q <= ten_sec;
         if (ten_sec != ten_q) begin
            ic_q <= '0;
         end else if (sec_tick) begin
            ic_q <= (ic_q == ic_last) ? 6'd0 : ic_q + 6'd1;
         end
      end
   end

   assign sign     = trim_sign_e'(trim[7:6]);
   assign due      = auto_en && run && (ic_q == 6'd0);
   assign trim_add = due && (sign == SGN_ADD);
   assign trim_sub = due && (sign == SGN_SUB);
   assign trim_n   = trim[TRIM_W-1:0];

   a_r10_interval_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && ic_q == ic_last && ten_sec == ten_q) |=> (ic_q == 6'd0));

   a_r10_interval_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ic_q <= LAST_SIXTY);

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
   import rtc_trim_pkg::*;
#(
   parameter int SEC_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [3:0]        rate,
   input  logic              trim_add,
   input  logic              trim_sub,
   input  logic [TRIM_W-1:0] trim_n,
   output logic              sec_tick,
   output logic              per_evt
);

   localparam logic [SEC_W-1:0] LAST = '1;

   generate
      if (SEC_W < 7 || SEC_W > 24) begin : g_bad_width
         $error("SEC_W must lie in 7..24");
      end
   endgenerate

   logic [SEC_W-1:0]  div_q;
   logic [TRIM_W-1:0] stall_q;
   logic              advance;
   logic              rate_ok;
   logic [7:0]        evt_vec;

   assign advance  = run && (stall_q == '0);
   assign sec_tick = advance && (div_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         stall_q <= '0;
      end else if (!run) begin
         div_q   <= '0;
         stall_q <= '0;
      end else if (stall_q != '0) begin
         stall_q <= stall_q - 1'b1;
      end else if (sec_tick) begin
         div_q   <= trim_add ? SEC_W'(trim_n) : '0;
         stall_q <= trim_sub ? trim_n : '0;
      end else begin
         div_q   <= div_q + 1'b1;
      end
   end

   generate
      for (genvar k = 0; k < RATE_COUNT; k++) begin : g_rate
         localparam int PW = SEC_W - 6 + k;
         assign evt_vec[k] = &div_q[PW-1:0];
      end
   endgenerate
   assign evt_vec[7] = 1'b0;

   assign rate_ok = rate[3] && (rate[2:0] != 3'd7);
   assign per_evt = advance && rate_ok && evt_vec[rate[2:0]];

   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sec_tick && !per_evt));

   a_r7_add_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && trim_add) |=> (div_q == $past(SEC_W'(trim_n))));

   a_r8_sub_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && trim_sub) |=> (stall_q == $past(trim_n) && div_q == '0));

endmodule

// File: rtl/rtc_prescaler_trim.sv
module rtc_prescaler_trim
   import rtc_trim_pkg::*;
#(
   parameter int SEC_W     = 15,
   parameter int GUARD_CYC = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       sec_tick,
   output logic       tick_period,
   output logic       irq_period
);

   logic [3:0]        rate;
   logic              pie, run, auto_en, ten_sec, flag;
   logic [7:0]        trim;
   logic              trim_add, trim_sub;
   logic [TRIM_W-1:0] trim_n;

   rtc_trim_regs #(.GUARD_CYC(GUARD_CYC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .per_evt (tick_period),
      .rate    (rate),
      .pie     (pie),
      .run     (run),
      .auto_en (auto_en),
      .ten_sec (ten_sec),
      .flag    (flag),
      .trim    (trim)
   );

   rtc_trim_interval u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .run      (run),
      .auto_en  (auto_en),
      .ten_sec  (ten_sec),
      .trim     (trim),
      .trim_add (trim_add),
      .trim_sub (trim_sub),
      .trim_n   (trim_n)
   );

   rtc_trim_divider #(.SEC_W(SEC_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .rate     (rate),
      .trim_add (trim_add),
      .trim_sub (trim_sub),
      .trim_n   (trim_n),
      .sec_tick (sec_tick),
      .per_evt  (tick_period)
   );

   assign irq_period = flag && pie;

   a_r6_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_period |-> (rd_addr != A_STAT || rd_data[BIT_FLAG]));

endmodule

// File: tb/tb_rtc_prescaler_trim.sv
module tb_rtc_prescaler_trim;

   localparam int SEC_W = 8;
   localparam int SEC   = 1 << SEC_W;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       sec_tick, tick_period, irq_period;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ts [0:62];

   localparam int NVEC = 9;
   localparam int VEC_CODE [0:NVEC-1] = '{8, 9, 10, 11, 12, 13, 14, 3, 15};
   localparam int VEC_PER  [0:NVEC-1] = '{4, 8, 16, 32, 64, 128, 256, 0, 0};

   rtc_prescaler_trim #(.SEC_W(SEC_W), .GUARD_CYC(6)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sec_tick(sec_tick), .tick_period(tick_period), .irq_period(irq_period)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic do_reset(input int settle);
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (settle) @(negedge clk);
   endtask

   task automatic next_sec(input int lim, output int t);
      t = -1;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (sec_tick) begin t = cyc; break; end
      end
   endtask

   task automatic next_per(input int lim, output int t);
      t = -1;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (tick_period) begin t = cyc; break; end
      end
   endtask

   task automatic capture(input int n);
      for (int i = 0; i < n; i++) next_sec(2 * SEC, ts[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v, t0, t1;

      // R1: reset state
      do_reset(8);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 register", v, 0);
      end
      check("R1 outputs", int'({sec_tick, tick_period, irq_period}), 0);

      // R2: a write in the first cycle after release is dropped, a later one lands
      do_reset(0);
      wr(2'd0, 8'h84);
      rd(2'd0, v);
      check("R2 early write", v, 0);
      repeat (6) @(negedge clk);
      wr(2'd0, 8'h84);
      rd(2'd0, v);
      check("R2 late write", v, 8'h84);

      // R3: stopped divider stays quiet
      do_reset(8);
      wr(2'd0, 8'h80);
      next_sec(3 * SEC, t0);
      check("R3 no tick stopped", t0, -1);
      next_per(3 * SEC, t0);
      check("R3 no period stopped", t0, -1);
      wr(2'd1, 8'h01);
      next_sec(2 * SEC, t0);
      next_sec(2 * SEC, t1);
      check("R3 second length", t1 - t0, SEC);

      // R4: rate table
      for (int i = 0; i < NVEC; i++) begin
         do_reset(8);
         wr(2'd0, 8'(VEC_CODE[i] << 4));
         wr(2'd1, 8'h01);
         next_per(3 * SEC, t0);
         if (VEC_PER[i] == 0) begin
            check("R4 no pulses", t0, -1);
         end else begin
            next_per(3 * SEC, t1);
            check("R4 period", t1 - t0, VEC_PER[i]);
         end
      end

      // R5, R6: flag and interrupt gating
      do_reset(8);
      wr(2'd0, 8'h80);
      wr(2'd1, 8'h01);
      next_per(100, t0);
      rd(2'd2, v);
      check("R5 flag set", v, 8'h04);
      check("R6 irq masked", int'(irq_period), 0);
      wr(2'd0, 8'h84);
      #1 check("R6 irq enabled", int'(irq_period), 1);
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h04);
      rd(2'd2, v);
      check("R5 write one keeps", v, 8'h04);
      wr(2'd2, 8'h00);
      rd(2'd2, v);
      check("R5 write zero clears", v, 0);
      check("R6 irq after clear", int'(irq_period), 0);

      // R7, R10: add 20 cycles every 10 s
      do_reset(8);
      wr(2'd1, 8'h20);
      wr(2'd3, 8'h54);
      wr(2'd1, 8'h31);
      capture(12);
      check("R7 add trimmed", ts[1] - ts[0], SEC - 20);
      check("R10 untrimmed middle", ts[6] - ts[5], SEC);
      check("R10 ten second repeat", ts[11] - ts[10], SEC - 20);

      // R8: subtract 20 cycles every 10 s
      do_reset(8);
      wr(2'd1, 8'h20);
      wr(2'd3, 8'h94);
      wr(2'd1, 8'h31);
      capture(12);
      check("R8 sub trimmed", ts[1] - ts[0], SEC + 20);
      check("R8 untrimmed next", ts[2] - ts[1], SEC);
      check("R10 sub repeat", ts[11] - ts[10], SEC + 20);

      // R9: reserved sign and disabled auto trim
      do_reset(8);
      wr(2'd1, 8'h20);
      wr(2'd3, 8'hD4);
      wr(2'd1, 8'h31);
      capture(3);
      check("R9 sign three", ts[1] - ts[0], SEC);
      do_reset(8);
      wr(2'd1, 8'h20);
      wr(2'd3, 8'h54);
      wr(2'd1, 8'h21);
      capture(3);
      check("R9 auto off", ts[1] - ts[0], SEC);

      // R10: 60 s interval
      do_reset(8);
      wr(2'd3, 8'h4A);
      wr(2'd1, 8'h11);
      capture(62);
      check("R10 sixty first", ts[1] - ts[0], SEC - 10);
      check("R10 sixty at ten", ts[11] - ts[10], SEC);
      check("R10 sixty repeat", ts[61] - ts[60], SEC - 10);

      // R11: interval bit locked while sign nonzero
      do_reset(8);
      wr(2'd3, 8'h45);
      wr(2'd1, 8'h20);
      rd(2'd1, v);
      check("R11 locked", v, 8'h00);
      wr(2'd1, 8'h21);
      rd(2'd1, v);
      check("R11 other bits land", v, 8'h01);
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h05);
      wr(2'd1, 8'h20);
      rd(2'd1, v);
      check("R11 unlocked", v, 8'h20);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule